// File: doc/BRIEF.md
# Buffered Capture/Compare Register Pair

This block is one sub-channel of a timer. It holds two registers side by side: a slave register that the CPU writes, and a master register that the timer logic compares against or captures into. A 16-bit configuration word chooses capture or compare operation. It also selects buffered or unbuffered handling, enables capture events, picks the point at which a buffered compare value is reloaded, and holds a two-bit timebase selection for the counter multiplexer outside the block. The counter value comes in from a free-running counter that lives elsewhere. The capture strobe is already edge-detected. The CPU's read of the master register arrives as a one-cycle strobe.

In unbuffered capture, the first enabled event stores the counter in the master register. Later events are then refused until the CPU reads the master register. In buffered capture, every event goes into the slave register, and each CPU read reloads the master register once from the slave register. In compare operation, the CPU writes the slave register. In unbuffered compare, the master register follows that write one cycle later. In buffered compare, the value waits and is moved either on an external reload strobe or when the counter reaches the current master value. Whenever the counter equals the master register in compare operation, a one-cycle match pulse is produced.

Top module: `capcmp_pair`

## Requirements
- R1: The configuration word resets to 0x0000 and is written as a whole 16-bit word by `cfgWr`. Bits 7:6 and 15:14 always read as zero, so writing 0xFFFF reads back 0x3F3F.
- R2: The word holds two six-bit fields, at bits 5:0 and bits 13:8. Parameter FIELD_SEL (0 = lower, 1 = upper, default 0) picks the field that drives this sub-channel, and the other field has no effect on it. Layout inside a field: bit 0 event enable, bit 1 buffer enable, bit 2 link, bit 3 mode (1 = compare, 0 = capture), bits 5:4 timebase select, driven on `tbSel`.
- R3: When event enable is 0, capture events change neither register and do not set `capValid`.
- R4: In unbuffered capture, an accepted event loads the counter into the master register and sets `capValid`, both visible after the next clock edge. While `capValid` is set, events are ignored. A cycle with `mstRd` clears `capValid`.
- R5: In buffered capture, every enabled event stores the counter in the slave register, and `capValid` is set. A cycle with `mstRd` copies the slave register into the master register at that clock edge, once per read.
- R6: When a capture event and `mstRd` fall in the same cycle, the read sees the old master value. In buffered capture the slave register takes the new count and the master register takes the previous slave value. In unbuffered capture the event is dropped and `capValid` ends up clear.
- R7: In unbuffered compare, a `slvWr` loads the slave register at the next edge, and the master register takes that value at the edge after.
- R8: In buffered compare with link set, the master register is loaded from the slave register only at the edge of a cycle in which `reloadStb` is high.
- R9: In buffered compare with link clear, the master register is loaded from the slave register at the edge of a cycle in which the counter equals the master register.
- R10: `matchPulse` is high for the cycle after each cycle in which the mode is compare and the counter equals the master register. It stays low in capture mode.
- R11: In capture mode, `slvWr` leaves the slave register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Write strobe for the configuration word |
| cfgWrData | input | 16 | Configuration word to write |
| cntVal | input | 16 | Free-running counter value |
| capEvt | input | 1 | Capture event strobe |
| mstRd | input | 1 | CPU read strobe of the master register |
| slvWr | input | 1 | CPU write strobe of the slave register |
| slvWrData | input | 16 | CPU write data for the slave register |
| reloadStb | input | 1 | External reload strobe for buffered compare |
| cfgQ | output | 16 | Configuration word read-back |
| tbSel | output | 2 | Timebase select of the active field |
| mstQ | output | 16 | Master register |
| slvQ | output | 16 | Slave register |
| capValid | output | 1 | A captured value awaits reading |
| matchPulse | output | 1 | One-cycle compare match |

## Verification
Directed sequences first walk each of the four mode combinations. They make an event hit a locked master register, put a read and an event in the same cycle, and enable only the unused field, which separates the lock-out, the read-first ordering and the field selection from plain capture. A buffered compare is run once with the link bit set and once with it clear. This shows whether the transfer follows the reload strobe or the counter match. Constrained random phases then switch among the modes. They draw counter and write values from a small range, so that matches, events during a lock and reads landing with writes happen often. Every output is compared each cycle with a model built from the requirements.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_MASK = 16'h3F3F;

  typedef struct packed {
    logic [1:0] tbSel;
    logic       cmpMode;
    logic       link;
    logic       bufEn;
    logic       evtEn;
  } chanField_t;

  typedef struct packed {
    logic mstFromCnt;
    logic mstFromSlv;
    logic slvFromCnt;
    logic slvFromCpu;
  } xferStb_t;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int FIELD_SEL = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             capEvt,
  input  logic             mstRd,
  input  logic             slvWr,
  input  logic             reloadStb,
  input  logic             cntEqMst,
  output logic [CFG_W-1:0] cfgQ,
  output logic [1:0]       tbSel,
  output xferStb_t         stb,
  output logic             capValid,
  output logic             matchPulse
);
  localparam int FIELD_W = $bits(chanField_t);
  localparam int FIELD_LO = (FIELD_SEL == 1) ? 8 : 0;

  logic [CFG_W-1:0] cfgReg;
  logic [FIELD_W-1:0] fldRaw;
  chanField_t fld;
  logic capMode;
  logic accept;
  logic copyPend;

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWr) cfgReg <= cfgWrData & CFG_MASK;
  end

  generate
    if (FIELD_SEL == 1) begin : g_upper
      assign fldRaw = cfgReg[FIELD_LO+FIELD_W-1:FIELD_LO];
    end else begin : g_lower
      assign fldRaw = cfgReg[FIELD_W-1:0];
    end
  endgenerate

  assign fld = chanField_t'(fldRaw);
  assign capMode = !fld.cmpMode;
  assign accept = capMode && fld.evtEn && capEvt && (fld.bufEn || (!capValid && !mstRd));

  always_comb begin
    stb.mstFromCnt = accept && !fld.bufEn;
    stb.slvFromCnt = accept && fld.bufEn;
    stb.slvFromCpu = fld.cmpMode && slvWr;
    if (capMode) stb.mstFromSlv = fld.bufEn && mstRd;
    else if (fld.bufEn) stb.mstFromSlv = fld.link ? reloadStb : cntEqMst;
    else stb.mstFromSlv = copyPend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid   <= 1'b0;
      copyPend   <= 1'b0;
      matchPulse <= 1'b0;
    end else begin
      capValid   <= accept || (capValid && !mstRd);
      copyPend   <= fld.cmpMode && !fld.bufEn && slvWr;
      matchPulse <= fld.cmpMode && cntEqMst;
    end
  end

  assign cfgQ  = cfgReg;
  assign tbSel = fld.tbSel;

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[7:6] == 2'b00) && (cfgQ[15:14] == 2'b00));

  // R3
  evt_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fld.evtEn |-> !stb.mstFromCnt && !stb.slvFromCnt);

  // R4
  capture_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capValid && capMode && !fld.bufEn && !mstRd) |-> !stb.mstFromCnt);

  // R10
  match_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capMode && !cfgWr) |=> !matchPulse);
endmodule

// File: rtl/capcmp_dp.sv
module capcmp_dp
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] slvWrData,
  input  xferStb_t         stb,
  output logic [CNT_W-1:0] mstQ,
  output logic [CNT_W-1:0] slvQ,
  output logic             cntEqMst
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mstQ <= '0;
      slvQ <= '0;
    end else begin
      if (stb.mstFromCnt) mstQ <= cntVal;
      else if (stb.mstFromSlv) mstQ <= slvQ;
      if (stb.slvFromCnt) slvQ <= cntVal;
      else if (stb.slvFromCpu) slvQ <= slvWrData;
    end
  end

  assign cntEqMst = (cntVal == mstQ);

  // R5
  mst_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mstFromSlv && !stb.mstFromCnt) |=> mstQ == $past(slvQ));

  // R5
  slv_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.slvFromCnt |=> slvQ == $past(cntVal));

  // R11
  slv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.slvFromCnt && !stb.slvFromCpu) |=> $stable(slvQ));
endmodule

// File: rtl/capcmp_pair.sv
module capcmp_pair
  import capcmp_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FIELD_SEL = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             capEvt,
  input  logic             mstRd,
  input  logic             slvWr,
  input  logic [CNT_W-1:0] slvWrData,
  input  logic             reloadStb,
  output logic [CFG_W-1:0] cfgQ,
  output logic [1:0]       tbSel,
  output logic [CNT_W-1:0] mstQ,
  output logic [CNT_W-1:0] slvQ,
  output logic             capValid,
  output logic             matchPulse
);
  xferStb_t stb;
  logic cntEqMst;

  capcmp_ctrl #(.FIELD_SEL(FIELD_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWrData(cfgWrData),
    .capEvt(capEvt), .mstRd(mstRd), .slvWr(slvWr), .reloadStb(reloadStb),
    .cntEqMst(cntEqMst), .cfgQ(cfgQ), .tbSel(tbSel), .stb(stb),
    .capValid(capValid), .matchPulse(matchPulse)
  );

  capcmp_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .slvWrData(slvWrData),
    .stb(stb), .mstQ(mstQ), .slvQ(slvQ), .cntEqMst(cntEqMst)
  );
endmodule

// File: tb/capcmp_pair_bench.sv
module capcmp_pair_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cntVal = '0;
  logic capEvt = 1'b0, mstRd = 1'b0, slvWr = 1'b0, reloadStb = 1'b0;
  logic [15:0] slvWrData = '0;
  logic [15:0] cfgQ, mstQ, slvQ;
  logic [1:0] tbSel;
  logic capValid, matchPulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] mCfg = '0, mMst = '0, mSlv = '0;
  logic mValid = 0, mPend = 0, mMatch = 0;

  always #2.5 clk = ~clk;

  capcmp_pair u_capcmp_pair (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgWrData(cfgWrData),
    .cntVal(cntVal), .capEvt(capEvt), .mstRd(mstRd), .slvWr(slvWr),
    .slvWrData(slvWrData), .reloadStb(reloadStb), .cfgQ(cfgQ), .tbSel(tbSel),
    .mstQ(mstQ), .slvQ(slvQ), .capValid(capValid), .matchPulse(matchPulse)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [15:0] c);
    if (c[3]) return c[1] ? (c[2] ? "R8" : "R9") : "R7";
    return c[1] ? "R5" : "R4";
  endfunction

  // Model step from the requirements, using values before the edge.
  task automatic modelStep();
    logic evt, buff, lnk, cmp, acc, eq;
    logic [15:0] oMst, oSlv;
    evt = mCfg[0]; buff = mCfg[1]; lnk = mCfg[2]; cmp = mCfg[3];
    oMst = mMst; oSlv = mSlv; eq = (cntVal == oMst);
    acc = !cmp && evt && capEvt && (buff || (!mValid && !mstRd));
    if (!rstN) begin
      mCfg = '0; mMst = '0; mSlv = '0; mValid = 0; mPend = 0; mMatch = 0;
    end else begin
      if (!cmp) begin
        if (buff) begin
          if (acc) mSlv = cntVal;
          if (mstRd) mMst = oSlv;
        end else if (acc) mMst = cntVal;
      end else begin
        if (slvWr) mSlv = slvWrData;
        if (!buff) begin
          if (mPend) mMst = oSlv;
        end else if (lnk ? reloadStb : eq) mMst = oSlv;
      end
      mValid = acc || (mValid && !mstRd);
      mPend = cmp && !buff && slvWr;
      mMatch = cmp && eq;
      if (cfgWr) mCfg = cfgWrData & 16'h3F3F;
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    modelStep();
    #2;
    chk(tag, "mstQ", mstQ, mMst);
    chk(tag, "slvQ", slvQ, mSlv);
    chk(tag, "capValid", {15'd0, capValid}, {15'd0, mValid});
    chk(tag, "matchPulse", {15'd0, matchPulse}, {15'd0, mMatch});
    chk(tag, "cfgQ", cfgQ, mCfg);
    chk(tag, "tbSel", {14'd0, tbSel}, {14'd0, mCfg[5:4]});
    cfgWr = 0; capEvt = 0; mstRd = 0; slvWr = 0; reloadStb = 0;
  endtask

  task automatic setCfg(input logic [15:0] v, input string tag);
    cfgWr = 1; cfgWrData = v;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    tick("R1"); tick("R1");
    rstN = 1;
    tick("R1");
    chk("R1", "reset cfgQ", cfgQ, 16'h0000);
    setCfg(16'hFFFF, "R1");
    chk("R1", "masked cfgQ", cfgQ, 16'h3F3F);
    setCfg(16'h0000, "R1");

    // R2: only the unused upper field enables events
    setCfg(16'h0100, "R2");
    cntVal = 16'd7; capEvt = 1; tick("R2");
    chk("R2", "upper field ignored mstQ", mstQ, 16'h0000);
    chk("R2", "upper field ignored valid", {15'd0, capValid}, 16'd0);

    // R3: events disabled; R10 no match in capture mode (cnt == mst == 0)
    setCfg(16'h0000, "R3");
    cntVal = 16'd0; capEvt = 1; tick("R3");
    tick("R10");
    chk("R10", "no match in capture", {15'd0, matchPulse}, 16'd0);

    // R4: unbuffered capture with lock
    setCfg(16'h0001, "R4");
    cntVal = 16'd5; capEvt = 1; tick("R4");
    chk("R4", "captured", mstQ, 16'd5);
    cntVal = 16'd9; capEvt = 1; tick("R4");
    chk("R4", "locked", mstQ, 16'd5);
    mstRd = 1; tick("R4");
    chk("R4", "valid cleared", {15'd0, capValid}, 16'd0);
    cntVal = 16'd11; capEvt = 1; tick("R4");
    chk("R4", "recaptured", mstQ, 16'd11);
    // R6 unbuffered: read and event together
    cntVal = 16'd12; capEvt = 1; mstRd = 1; tick("R6");
    chk("R6", "unbuf event dropped", mstQ, 16'd11);
    chk("R6", "unbuf valid clear", {15'd0, capValid}, 16'd0);

    // R5: buffered capture
    setCfg(16'h0003, "R5");
    cntVal = 16'd20; capEvt = 1; tick("R5");
    chk("R5", "slave captured", slvQ, 16'd20);
    chk("R5", "master held", mstQ, 16'd11);
    mstRd = 1; tick("R5");
    chk("R5", "master reloaded", mstQ, 16'd20);
    cntVal = 16'd21; capEvt = 1; tick("R5");
    cntVal = 16'd22; capEvt = 1; tick("R5");
    mstRd = 1; tick("R5");
    chk("R5", "reload latest", mstQ, 16'd22);
    cntVal = 16'd30; capEvt = 1; mstRd = 1; tick("R6");
    chk("R6", "buf master old slave", mstQ, 16'd22);
    chk("R6", "buf slave new count", slvQ, 16'd30);

    // R11: slave write ignored in capture mode
    slvWr = 1; slvWrData = 16'h0077; tick("R11");
    chk("R11", "slave unchanged", slvQ, 16'd30);

    // R7: unbuffered compare
    cntVal = 16'd0;
    setCfg(16'h0008, "R7");
    slvWr = 1; slvWrData = 16'h0040; tick("R7");
    chk("R7", "slave written", slvQ, 16'h0040);
    chk("R7", "master not yet", mstQ, 16'd22);
    tick("R7");
    chk("R7", "master copied", mstQ, 16'h0040);

    // R10: match pulse
    cntVal = 16'h0040; tick("R10");
    chk("R10", "match high", {15'd0, matchPulse}, 16'd1);
    cntVal = 16'h0041; tick("R10");
    chk("R10", "match low", {15'd0, matchPulse}, 16'd0);

    // R8: buffered compare, reload strobe
    setCfg(16'h000E, "R8");
    slvWr = 1; slvWrData = 16'h0055; tick("R8");
    tick("R8");
    chk("R8", "waits for strobe", mstQ, 16'h0040);
    reloadStb = 1; tick("R8");
    chk("R8", "reloaded", mstQ, 16'h0055);

    // R9: buffered compare, reload on match
    setCfg(16'h000A, "R9");
    slvWr = 1; slvWrData = 16'h0066; tick("R9");
    cntVal = 16'h0010; tick("R9");
    chk("R9", "no match no reload", mstQ, 16'h0055);
    cntVal = 16'h0055; tick("R9");
    chk("R9", "reloaded on match", mstQ, 16'h0066);

    // Random phases
    for (int ph = 0; ph < 20; ph++) begin
      setCfg(16'($urandom) & 16'h3F3F, "R2");
      for (int i = 0; i < 150; i++) begin
        cntVal    = 16'($urandom % 8);
        slvWrData = 16'($urandom % 8);
        capEvt    = ($urandom % 3) == 0;
        mstRd     = ($urandom % 4) == 0;
        slvWr     = ($urandom % 4) == 0;
        reloadStb = ($urandom % 5) == 0;
        tick(modeTag(mCfg));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule